// File: doc/BRIEF.md
# Reference-Windowed Clock Frequency Meter

This block reports the frequency of eight monitored clocks in MHz. Its own clock is the reference. A programmable register holds the reference frequency in MHz. The block opens a measurement window that lasts exactly that many reference cycles. During the window it counts the rising edges of each monitored signal. At the end of the window the count therefore equals the monitored frequency in MHz. If the reference register does not match the true reference, software scales the reading by (true reference / register value).

Each monitored clock arrives as a toggle signal. It passes through a two-flop synchronizer and a rising-edge detector before it is counted. The eight 16-bit counts are latched together at the end of every window. They are packed two to a 32-bit result word:

- fastest clock with the crypto clock;
- always-on clock with the always-on RAM clock;
- internal oscillator with the crystal;
- PLL output 0 with PLL output 1.

A status word tells software whether the result words hold a complete measurement.

Top module: `freq_meter`

## Requirements
- R1: After reset, `ref_mhz` reads 48, all four result words read 0 and `meas_valid` reads 0x00; the default window of 48 cycles then runs without any write.
- R2: A cycle with `ref_we` high loads `ref_wdata` into the reference register, and `ref_mhz` shows the new value from the next cycle.
- R3: A window spans exactly `ref_mhz` reference cycles, counted from the write or from the end of the previous window. The latched count for an input equals the number of rising edges it shows in that span, so an input with period P cycles gives `ref_mhz`/P.
- R4: Result word k carries `mon_tog[2k]` in bits [31:16] and `mon_tog[2k+1]` in bits [15:0]. Inputs 0..7 are the fastest, crypto, always-on, always-on RAM, oscillator, crystal, PLL 0 and PLL 1 clocks.
- R5: All eight counts are latched in the same cycle at the end of a window, and every window refreshes them. Between window ends, a write to the reference register included, the result words hold their value.
- R6: A count that reaches 0xFFFF stays at 0xFFFF for the rest of the window instead of wrapping.
- R7: `meas_valid` reads only 0x00 or 0x0F. It is 0x00 from reset and from any reference write until a full window completes, and 0x0F afterwards.
- R8: A reference value of 0 stops measurement: no window ends, `meas_valid` stays 0x00 and the result words keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_we | input | 1 | Write strobe for the reference register |
| ref_wdata | input | 32 | Reference frequency in MHz to load |
| mon_tog | input | 8 | Monitored clocks as toggle signals |
| ref_mhz | output | 32 | Reference register readback |
| meas_core_crypto | output | 32 | Fastest clock [31:16], crypto clock [15:0] |
| meas_aon | output | 32 | Always-on clock [31:16], always-on RAM clock [15:0] |
| meas_osc_xtal | output | 32 | Internal oscillator [31:16], crystal [15:0] |
| meas_pll | output | 32 | PLL output 0 [31:16], PLL output 1 [15:0] |
| meas_valid | output | 32 | 0x0F when the results are valid, 0x00 otherwise |

## Verification
The hardest condition to reach is counter saturation. A toggle input produces at most one rising edge every two cycles, so crossing 0xFFFF needs a window longer than 131070 cycles. The bench programs a window of 131200 cycles and drives the fastest possible toggle on most inputs, with one slower input that stays below the limit. A second difficult case is a change in input rates while windows keep running without a new write. The bench changes the rates just after a known window end, skips the mixed window that follows, and checks the first window that sees only the new rates.

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int REF_W     = 32,
  parameter int CNT_W     = 16,
  parameter int REF_RESET = 48,
  parameter logic [31:0] VALID_CODE = 32'h0000_000F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_we,
  input  logic [REF_W-1:0]   ref_wdata,
  input  logic [7:0]         mon_tog,
  output logic [REF_W-1:0]   ref_mhz,
  output logic [2*CNT_W-1:0] meas_core_crypto,
  output logic [2*CNT_W-1:0] meas_aon,
  output logic [2*CNT_W-1:0] meas_osc_xtal,
  output logic [2*CNT_W-1:0] meas_pll,
  output logic [31:0]        meas_valid
);
  localparam int NUM_MON = 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_MON-1:0] sync1, sync2, prev;
  logic [NUM_MON-1:0] rise;
  logic [REF_W-1:0]   ref_q;
  logic [REF_W-1:0]   win_cnt;
  logic [CNT_W-1:0]   cnt [NUM_MON];
  logic [CNT_W-1:0]   res [NUM_MON];
  logic               valid_q;
  logic               win_end;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c, input logic e);
    return (e && c != CNT_MAX) ? c + 1'b1 : c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= mon_tog;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign rise    = sync2 & ~prev;
  assign win_end = (ref_q != '0) && (win_cnt == ref_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= REF_W'(REF_RESET);
      win_cnt <= '0;
      valid_q <= 1'b0;
      for (int i = 0; i < NUM_MON; i++) begin
        cnt[i] <= '0;
        res[i] <= '0;
      end
    end else if (ref_we) begin
      ref_q   <= ref_wdata;
      win_cnt <= '0;
      valid_q <= 1'b0;
      for (int i = 0; i < NUM_MON; i++) cnt[i] <= '0;
    end else if (ref_q == '0) begin
      win_cnt <= '0;
      valid_q <= 1'b0;
      for (int i = 0; i < NUM_MON; i++) cnt[i] <= '0;
    end else if (win_end) begin
      win_cnt <= '0;
      valid_q <= 1'b1;
      for (int i = 0; i < NUM_MON; i++) begin
        res[i] <= bump(cnt[i], rise[i]);
        cnt[i] <= '0;
      end
    end else begin
      win_cnt <= win_cnt + 1'b1;
      for (int i = 0; i < NUM_MON; i++) cnt[i] <= bump(cnt[i], rise[i]);
    end
  end

  assign ref_mhz          = ref_q;
  assign meas_core_crypto = {res[0], res[1]};
  assign meas_aon         = {res[2], res[3]};
  assign meas_osc_xtal    = {res[4], res[5]};
  assign meas_pll         = {res[6], res[7]};
  assign meas_valid       = valid_q ? VALID_CODE : 32'h0;

  assert_ref_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_we |=> ref_mhz == $past(ref_wdata))
    else $error("reference register did not load");

  assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q != '0) |-> (win_cnt < ref_q))
    else $error("window counter beyond reference value");

  assert_results_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> ($stable(meas_core_crypto) && $stable(meas_aon) &&
                  $stable(meas_osc_xtal) && $stable(meas_pll)))
    else $error("results changed outside a window end");

  assert_valid_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid == 32'h0) || (meas_valid == VALID_CODE))
    else $error("status holds an illegal code");

  assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_we |=> meas_valid == 32'h0)
    else $error("status not cleared by reference write");

  assert_zero_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_mhz == '0) |-> (meas_valid == 32'h0))
    else $error("status valid while measurement disabled");

  for (genvar g = 0; g < NUM_MON; g++) begin : g_sat
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[g] == CNT_MAX && !ref_we && !win_end && ref_q != '0) |=> cnt[g] == CNT_MAX)
      else $error("edge counter wrapped");
  end
endmodule

// File: tb/tb_freq_meter.sv
module tb_freq_meter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_we = 1'b0;
  logic [31:0] ref_wdata = '0;
  logic [7:0]  mon_tog;
  logic [31:0] ref_mhz, meas_core_crypto, meas_aon, meas_osc_xtal, meas_pll, meas_valid;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  freq_meter dut (
    .clk(clk), .rst_n(rst_n), .ref_we(ref_we), .ref_wdata(ref_wdata),
    .mon_tog(mon_tog), .ref_mhz(ref_mhz), .meas_core_crypto(meas_core_crypto),
    .meas_aon(meas_aon), .meas_osc_xtal(meas_osc_xtal), .meas_pll(meas_pll),
    .meas_valid(meas_valid)
  );

  // toggle generators: half period in cycles per input, 0 holds low
  logic [7:0] hp [8];
  logic [7:0] gcnt [8];
  logic       gen_rst = 1'b1;

  always @(negedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (gen_rst || hp[i] == 8'd0) begin
        gcnt[i] <= 8'd0;
        mon_tog[i] <= 1'b0;
      end else if (gcnt[i] == hp[i] - 8'd1) begin
        gcnt[i] <= 8'd0;
        mon_tog[i] <= ~mon_tog[i];
      end else begin
        gcnt[i] <= gcnt[i] + 8'd1;
      end
    end
  end

  // {window, half periods of inputs 7..0}
  localparam int NV = 5;
  localparam logic [95:0] VEC [NV] = '{
    {32'd48,  8'd24, 8'd12, 8'd8,  8'd6,  8'd4,  8'd3,  8'd2,  8'd1},
    {32'd48,  8'd1,  8'd2,  8'd3,  8'd4,  8'd6,  8'd8,  8'd12, 8'd24},
    {32'd120, 8'd0,  8'd10, 8'd6,  8'd5,  8'd4,  8'd3,  8'd2,  8'd1},
    {32'd24,  8'd3,  8'd2,  8'd1,  8'd0,  8'd1,  8'd2,  8'd3,  8'd6},
    {32'd200, 8'd100,8'd50, 8'd25, 8'd20, 8'd10, 8'd5,  8'd4,  8'd1}
  };

  function automatic logic [15:0] expc(input logic [31:0] w, input logic [7:0] h);
    logic [31:0] q;
    if (h == 8'd0) return 16'd0;
    q = w / (32'd2 * {24'd0, h});
    return (q > 32'd65535) ? 16'hFFFF : q[15:0];
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic set_hp(input logic [63:0] p);
    @(negedge clk);
    gen_rst = 1'b1;
    for (int i = 0; i < 8; i++) hp[i] = p[8*i +: 8];
    @(negedge clk);
    gen_rst = 1'b0;
  endtask

  task automatic write_ref(input logic [31:0] v);
    @(negedge clk);
    ref_we = 1'b1;
    ref_wdata = v;
    @(negedge clk);
    ref_we = 1'b0;
  endtask

  task automatic chk_results(input string req, input logic [31:0] w, input logic [63:0] p);
    chk(req, "fast/crypto", meas_core_crypto, {expc(w, p[7:0]),   expc(w, p[15:8])});
    chk(req, "aon/aonram",  meas_aon,         {expc(w, p[23:16]), expc(w, p[31:24])});
    chk(req, "osc/xtal",    meas_osc_xtal,    {expc(w, p[39:32]), expc(w, p[47:40])});
    chk(req, "pll0/pll1",   meas_pll,         {expc(w, p[55:48]), expc(w, p[63:56])});
  endtask

  task automatic run_vec(input logic [95:0] v);
    logic [31:0] w;
    logic [31:0] old0, old1, old2, old3;
    w = v[95:64];
    set_hp(v[63:0]);
    repeat (10) @(negedge clk);
    old0 = meas_core_crypto; old1 = meas_aon; old2 = meas_osc_xtal; old3 = meas_pll;
    write_ref(w);
    chk("R2", "ref readback", ref_mhz, w);
    chk("R7", "valid after write", meas_valid, 32'h0);
    chk("R5", "hold fast/crypto on write", meas_core_crypto, old0);
    chk("R5", "hold pll on write", meas_pll, old3);
    chk("R5", "hold aon+osc on write", meas_aon ^ meas_osc_xtal, old1 ^ old2);
    repeat (w - 1) @(negedge clk);
    chk("R7", "valid one cycle before window end", meas_valid, 32'h0);
    @(negedge clk);
    chk("R7", "valid at window end", meas_valid, 32'h0F);
    chk_results("R3/R4", w, v[63:0]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) hp[i] = 8'd0;
    repeat (3) @(negedge clk);
    gen_rst = 1'b0;
    rst_n = 1'b1;
    // R1 reset state and default window
    chk("R1", "ref reset", ref_mhz, 32'd48);
    chk("R1", "result reset", meas_core_crypto | meas_aon | meas_osc_xtal | meas_pll, 32'h0);
    chk("R1", "valid reset", meas_valid, 32'h0);
    repeat (47) @(negedge clk);
    chk("R7", "valid before first window end", meas_valid, 32'h0);
    @(negedge clk);
    chk("R1", "default window completes", meas_valid, 32'h0F);
    chk("R1", "static inputs count zero", meas_core_crypto | meas_pll, 32'h0);

    for (int v = 0; v < NV; v++) run_vec(VEC[v]);

    // R5: refresh every window without a write
    run_vec(VEC[0]);
    set_hp(VEC[1][63:0]);
    chk_results("R5", 32'd48, VEC[0][63:0]);
    repeat (94) @(negedge clk);
    chk_results("R5", 32'd48, VEC[1][63:0]);

    // R6: saturation over a long window
    run_vec({32'd131200, 8'd2, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1});
    chk("R6", "saturated fast", {16'd0, meas_core_crypto[31:16]}, 32'h0000_FFFF);
    chk("R6", "unsaturated pll1", {16'd0, meas_pll[15:0]}, 32'd32800);

    // R8: zero reference disables measurement
    write_ref(32'd0);
    chk("R8", "ref zero readback", ref_mhz, 32'd0);
    chk("R8", "valid cleared", meas_valid, 32'h0);
    repeat (300) @(negedge clk);
    chk("R8", "valid stays clear", meas_valid, 32'h0);
    chk("R8", "results held", meas_core_crypto, 32'hFFFF_FFFF);
    chk("R8", "results held pll", meas_pll, 32'hFFFF_8020);

    summary();
  end
endmodule